// File: doc/BRIEF.md
# Writeback Slot Reservation for Fixed-Latency Units

This block decides, at issue time, whether an instruction may enter a fixed-latency execution unit. Several result buses carry results into writeback. Each bus has a reservation vector indexed by "cycles from now", and the same holds for each pipelined unit. Every vector moves one position toward the present on every clock. A request names a target unit, a latency L and whether that target can stall. For a non-stallable target the block looks for the lowest-numbered bus whose slot L is still open. It also checks that the unit's dispatch stage is idle and that the unit has no other result finishing in that same cycle. If all of these hold, it grants the issue and books slot L on both the chosen bus and the unit.

A stallable target, such as the memory pipe, skips the bus and occupancy checks entirely. It is granted whenever its own dispatch stage is free. The chosen bus index is also driven out for debug, with a flag that is low when no bus is open at the requested latency.

Top module: `wb_slot_reserve`

## Requirements
- R1: After a synchronous active-low reset, every bus and occupancy vector is clear: `bus_ok` is 1 and `bus_idx` is 0 for every in-range latency.
- R2: `bus_ok` is 1 exactly when the latency is below DEPTH and at least one bus has slot L open; `bus_idx` then gives the lowest such bus index.
- R3: A granted non-stallable request books slot L of the bus shown on `bus_idx`. A second request that finishes in the same cycle is placed on the next bus.
- R4: All vectors advance one position per clock. A booking made with latency L blocks a request with latency L-d issued d cycles later, but not a request with latency L issued one cycle later.
- R5: When every bus is booked at the finish cycle, a non-stallable request is denied and `bus_ok` is 0.
- R6: A non-stallable request is denied when its unit's `unit_busy` bit is set or when `req_unit` is not below NUM_UNIT.
- R7: A granted non-stallable request books slot L in its own unit's occupancy vector. A later request to the same unit that finishes in the same cycle is denied; other units are unaffected.
- R8: A stallable request (`req_stallable`=1) ignores buses, occupancy and latency. It is granted when `mem_busy` is 0 and books nothing.
- R9: A stallable request is denied when `mem_busy` is 1.
- R10: A non-stallable request with `req_lat` >= DEPTH raises `lat_err` and is denied. `lat_err` is never high for a stallable request.
- R11: A denied request books no bus and no occupancy slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Issue request present |
| req_stallable | input | 1 | 1 = target is the stallable memory pipe |
| req_unit | input | UIW | Target pipelined unit index |
| req_lat | input | LW | Latency in cycles until writeback |
| unit_busy | input | NUM_UNIT | Dispatch stage busy, per pipelined unit |
| mem_busy | input | 1 | Dispatch stage of the memory pipe is busy |
| grant | output | 1 | Issue accepted this cycle |
| bus_ok | output | 1 | A bus is open at `req_lat` |
| bus_idx | output | BIW | Lowest open bus index (debug) |
| lat_err | output | 1 | Non-stallable latency out of range |

## Verification
The hardest case to reach from the ports is a request denied only because every bus is full, while its own unit is idle and has no clash in its occupancy vector. Reaching it takes several grants to different units whose finish cycles line up across shifting vectors. The bench creates this by issuing to unit 0 with latency L, then to unit 1 with L-1, then to unit 2 with L-2, across the whole latency range. A long pseudo-random run then mixes units, including out-of-range ones, latencies, busy flags and stallable requests. It checks every cycle against a bit-level model of the requirements.

// File: rtl/wb_slot_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the writeback slot reservation block.
// Assumes: callers pass positive counts.
package wb_slot_pkg;
    // Width of an index able to address n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/wb_slot_vec.sv
`timescale 1ns/1ps
// Module: wb_slot_vec
// A latency-indexed booking vector. Bit k set means "taken k cycles from now".
// On every clock the vector moves one place toward bit 0, and a requested
// booking is merged in before the move, so it is seen at idx-1 next cycle.
// Assumes: idx < DEPTH whenever set_en is high (the parent gates this).
module wb_slot_vec #(
    parameter int DEPTH = 512,
    localparam int IW = wb_slot_pkg::idx_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] idx,
    output logic          taken
);
    logic [DEPTH-1:0] slots;
    logic [DEPTH-1:0] book;

    // One-hot booking for the requested slot.
    always_comb book = set_en ? (DEPTH'(1) << idx) : '0;

    // Lookup of the requested slot.
    always_comb taken = slots[idx];

    // Merge booking, then advance toward the present; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) slots <= '0;
        else        slots <= (slots | book) >> 1;
    end
endmodule

// File: rtl/wb_bus_pick.sv
`timescale 1ns/1ps
// Module: wb_bus_pick
// Fixed-priority search: returns the lowest index whose open bit is set.
// Assumes: nothing about the input pattern; found is low for all-zero.
module wb_bus_pick #(
    parameter int NUM_BUS = 2,
    localparam int BIW = wb_slot_pkg::idx_w(NUM_BUS)
) (
    input  logic [NUM_BUS-1:0] open_bus,
    output logic               found,
    output logic [BIW-1:0]     pick
);
    // Scan from the top down so the lowest open bus wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int b = NUM_BUS - 1; b >= 0; b--) begin
            if (open_bus[b]) begin
                found = 1'b1;
                pick  = BIW'(b);
            end
        end
    end
endmodule

// File: rtl/wb_slot_reserve.sv
`timescale 1ns/1ps
// Module: wb_slot_reserve (top)
// Issue-time writeback arbitration for fixed-latency units. One booking
// vector per result bus and one per pipelined unit. Non-stallable requests
// need an open bus at the latency plus a free, non-clashing unit; stallable
// requests need only a free memory dispatch stage.
// Assumes: DEPTH is a power of two; decisions are combinational in the
// request cycle, and bookings take effect from the next clock.
module wb_slot_reserve #(
    parameter int DEPTH    = 512,
    parameter int NUM_BUS  = 2,
    parameter int NUM_UNIT = 2,
    localparam int IW  = wb_slot_pkg::idx_w(DEPTH),
    localparam int LW  = IW + 1,
    localparam int BIW = wb_slot_pkg::idx_w(NUM_BUS),
    localparam int UIW = wb_slot_pkg::idx_w(NUM_UNIT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_stallable,
    input  logic [UIW-1:0]      req_unit,
    input  logic [LW-1:0]       req_lat,
    input  logic [NUM_UNIT-1:0] unit_busy,
    input  logic                mem_busy,
    output logic                grant,
    output logic                bus_ok,
    output logic [BIW-1:0]      bus_idx,
    output logic                lat_err
);
    logic                lat_in;
    logic [IW-1:0]       slot;
    logic [NUM_BUS-1:0]  bus_taken;
    logic [NUM_BUS-1:0]  bus_open;
    logic [NUM_BUS-1:0]  bus_set;
    logic [NUM_UNIT-1:0] unit_sel;
    logic [NUM_UNIT-1:0] occ_taken;
    logic [NUM_UNIT-1:0] occ_set;
    logic                unit_ok;
    logic                grant_fixed;
    logic                grant_mem;

    // Range check and slot index derived from the request latency.
    always_comb begin
        lat_in = (req_lat < LW'(DEPTH));
        slot   = req_lat[IW-1:0];
    end

    // Booking vector per result bus.
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        wb_slot_vec #(.DEPTH(DEPTH)) u_vec (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (bus_set[b]),
            .idx    (slot),
            .taken  (bus_taken[b])
        );
        // A bus is open only for an in-range latency with a clear slot.
        assign bus_open[b] = lat_in & ~bus_taken[b];
        // Book this bus when a fixed-latency grant chose it.
        assign bus_set[b]  = grant_fixed & (bus_idx == BIW'(b));
    end

    // Lowest-index open bus search.
    wb_bus_pick #(.NUM_BUS(NUM_BUS)) u_pick (
        .open_bus (bus_open),
        .found    (bus_ok),
        .pick     (bus_idx)
    );

    // Occupancy vector per pipelined unit.
    for (genvar u = 0; u < NUM_UNIT; u++) begin : g_unit
        assign unit_sel[u] = (req_unit == UIW'(u));
        wb_slot_vec #(.DEPTH(DEPTH)) u_occ (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (occ_set[u]),
            .idx    (slot),
            .taken  (occ_taken[u])
        );
        // Book the unit's finish slot on a fixed-latency grant to it.
        assign occ_set[u] = grant_fixed & unit_sel[u];
    end

    // Grant decision for both request kinds.
    always_comb begin
        unit_ok     = |(unit_sel & ~unit_busy & ~occ_taken);
        grant_fixed = req_valid & ~req_stallable & lat_in & bus_ok & unit_ok;
        grant_mem   = req_valid & req_stallable & ~mem_busy;
        grant       = grant_fixed | grant_mem;
        lat_err     = req_valid & ~req_stallable & ~lat_in;
    end
endmodule

// File: rtl/wb_slot_reserve_chk.sv
`timescale 1ns/1ps
// Module: wb_slot_reserve_chk
// Port-level properties of the reservation block, bound to every instance.
// Assumes: the same parameter values as the bound instance.
module wb_slot_reserve_chk #(
    parameter int DEPTH    = 512,
    parameter int NUM_BUS  = 2,
    parameter int NUM_UNIT = 2,
    localparam int IW  = wb_slot_pkg::idx_w(DEPTH),
    localparam int LW  = IW + 1,
    localparam int BIW = wb_slot_pkg::idx_w(NUM_BUS),
    localparam int UIW = wb_slot_pkg::idx_w(NUM_UNIT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_stallable,
    input logic [UIW-1:0]      req_unit,
    input logic [LW-1:0]       req_lat,
    input logic [NUM_UNIT-1:0] unit_busy,
    input logic                mem_busy,
    input logic                grant,
    input logic                bus_ok,
    input logic [BIW-1:0]      bus_idx,
    input logic                lat_err
);
    AST_BAD_LAT_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        lat_err |-> !grant);                                               // R10
    AST_STALL_NO_LAT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_stallable |-> !lat_err);                                       // R10
    AST_NO_BUS_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_stallable && !bus_ok) |-> !grant);              // R5
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ok |-> (int'(bus_idx) < NUM_BUS));                             // R2
    AST_MEM_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_stallable && !mem_busy) |-> grant);              // R8
    AST_MEM_BUSY_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_stallable && mem_busy) |-> !grant);              // R9
    AST_SAME_FINISH_SAME_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(grant && req_valid && !req_stallable) &&
         req_valid && !req_stallable && req_unit == $past(req_unit) &&
         $past(req_lat) != '0 && req_lat == $past(req_lat) - 1'b1) |-> !grant); // R7
endmodule

bind wb_slot_reserve wb_slot_reserve_chk #(
    .DEPTH(DEPTH), .NUM_BUS(NUM_BUS), .NUM_UNIT(NUM_UNIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_stallable(req_stallable), .req_unit(req_unit), .req_lat(req_lat),
    .unit_busy(unit_busy), .mem_busy(mem_busy), .grant(grant),
    .bus_ok(bus_ok), .bus_idx(bus_idx), .lat_err(lat_err)
);

// File: tb/wb_slot_reserve_test.sv
`timescale 1ns/1ps
// Bench: sweeps a small configuration (DEPTH 16, 2 buses, 3 units) against
// a bit-level model written from the requirements.
module wb_slot_reserve_test;
    localparam int DEPTH = 16;
    localparam int NB    = 2;
    localparam int NU    = 3;
    localparam int LW    = 5;
    localparam int UIW   = 2;
    localparam int BIW   = 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_stallable = 1'b0;
    logic [UIW-1:0] req_unit = '0;
    logic [LW-1:0]  req_lat = '0;
    logic [NU-1:0]  unit_busy = '0;
    logic           mem_busy = 1'b0;
    logic           grant, bus_ok, lat_err;
    logic [BIW-1:0] bus_idx;

    int checks = 0;
    int errors = 0;
    logic [DEPTH-1:0] mbus [NB];
    logic [DEPTH-1:0] mocc [NU];

    wb_slot_reserve #(.DEPTH(DEPTH), .NUM_BUS(NB), .NUM_UNIT(NU)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_stallable(req_stallable), .req_unit(req_unit), .req_lat(req_lat),
        .unit_busy(unit_busy), .mem_busy(mem_busy), .grant(grant),
        .bus_ok(bus_ok), .bus_idx(bus_idx), .lat_err(lat_err)
    );

    always #4 clk = ~clk;

    task automatic check(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // One request cycle: drive at negedge, compare, book in model, advance.
    task automatic step(input bit v, input bit st, input int u, input int lat,
                        input logic [NU-1:0] busy, input bit mb, input string tag);
        bit lat_in, ok, eg, ue;
        int ei;
        @(negedge clk);
        req_valid = v; req_stallable = st; req_unit = UIW'(u);
        req_lat = LW'(lat); unit_busy = busy; mem_busy = mb;
        #1;
        lat_in = (lat < DEPTH);
        ok = 0; ei = 0;
        for (int b = NB - 1; b >= 0; b--)
            if (lat_in && !mbus[b][lat[3:0]]) begin ok = 1; ei = b; end
        ue = (u < NU) && lat_in;
        if (ue) ue = !busy[u] && !mocc[u][lat[3:0]];
        eg = st ? (v && !mb) : (v && lat_in && ok && ue);
        check(int'(grant), int'(eg), tag, "grant");
        check(int'(bus_ok), int'(ok), tag, "bus_ok");
        if (ok) check(int'(bus_idx), ei, tag, "bus_idx");
        check(int'(lat_err), int'(v && !st && !lat_in), tag, "lat_err");
        if (eg && !st) begin
            mbus[ei][lat[3:0]] = 1'b1;
            mocc[u][lat[3:0]] = 1'b1;
        end
        @(posedge clk);
        for (int b = 0; b < NB; b++) mbus[b] = mbus[b] >> 1;
        for (int k = 0; k < NU; k++) mocc[k] = mocc[k] >> 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, i % DEPTH, '0, 0, "R4");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        for (int b = 0; b < NB; b++) mbus[b] = '0;
        for (int k = 0; k < NU; k++) mocc[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: every slot open after reset
        for (int l = 0; l < DEPTH; l++) step(0, 0, 0, l, '0, 0, "R1");
        // R3, R5, R8: align finish cycles on both buses, then overflow
        for (int l = 3; l < DEPTH; l++) begin
            step(1, 0, 0, l,     '0, 0, "R3");
            step(1, 0, 1, l - 1, '0, 0, "R3");
            step(1, 0, 2, l - 2, '0, 0, "R5");
            step(1, 1, 2, l - 3, '0, 0, "R8");
            step(1, 0, 2, l - 4 + 1, '0, 0, "R11");
            idle(DEPTH);
        end
        // R4: same latency one cycle later does not clash
        for (int l = 1; l < DEPTH; l++) begin
            step(1, 0, 0, l, '0, 0, "R4");
            step(1, 0, 1, l, '0, 0, "R4");
            idle(DEPTH);
        end
        // R7: same unit, same finish cycle; another unit unaffected
        for (int l = 2; l < DEPTH; l++) begin
            step(1, 0, 0, l,     '0, 0, "R7");
            step(1, 0, 0, l - 1, '0, 0, "R7");
            step(1, 0, 1, l - 2, '0, 0, "R7");
            idle(DEPTH);
        end
        // R6: busy units and out-of-range unit index
        for (int u = 0; u < 4; u++) step(1, 0, u, 5, 3'b111, 0, "R6");
        step(1, 0, 3, 5, '0, 0, "R6");
        // R9: memory pipe busy; R8 with buses full
        step(1, 0, 0, 6, '0, 0, "R8");
        step(1, 0, 1, 5, '0, 0, "R8");
        step(1, 1, 0, 4, '0, 0, "R8");
        step(1, 1, 0, 4, '0, 1, "R9");
        idle(DEPTH);
        // R10: out-of-range latencies
        for (int l = DEPTH; l < 32; l++) begin
            step(1, 0, 0, l, '0, 0, "R10");
            step(1, 1, 0, l, '0, 0, "R10");
        end
        // R2: pseudo-random mix against the model
        r = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            step(r[0] | r[1], r[2] & r[3] & r[4], int'(r[6:5]), int'(r[11:7]) % 20,
                 {r[12] & r[13], r[14] & r[9], r[15] & r[8]}, r[10] & r[5], "R2");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule